// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits at the front of a microcontroller's 1 MB private peripheral window (absolute addresses 0xE0000000 to 0xE00FFFFF). For every access it chooses one of three destinations: the system-register target, the timer-register target nested inside it, or a built-in default responder that answers on behalf of every address that no target claims. It forwards the offset relative to the chosen target's base. For the default responder it produces the completion itself.

Overlapping ranges are resolved by a fixed ranking. The timer ranks above the system registers, and the system registers rank above the default responder, which covers the whole window. Unclaimed space is read-as-zero and write-ignored for privileged accesses. Unprivileged accesses to it fault. When the security-extension parameter is set, non-secure alias copies of both targets appear 0x20000 higher in the window, and responses from them carry a non-secure-view flag.

The decode is registered. Each response appears in the cycle after the request strobe, and back-to-back requests are accepted every cycle. The upstream fabric presents only addresses that fall inside the window.

Top module: `ppb_window_decoder`

## Requirements
- R1: A request with `req_valid` high in one cycle yields `rsp_valid` high in the next cycle. In a cycle after one without a request, `rsp_valid`, all three selects, `rsp_error` and `rsp_ns_view` are low.
- R2: Whenever `rsp_valid` is high, exactly one of `sel_timer`, `sel_sysreg`, `sel_default` is high.
- R3: Only address bits [19:0] (the window offset) affect the decode. Bits [31:20] have no effect.
- R4: Window offsets 0xE010 to 0xE0EF select the timer with `rsp_offset` = offset − 0xE010, `rsp_ns_view` = 0 and no error.
- R5: Window offsets 0xE000 to 0xEFFF outside the timer range select the system registers with `rsp_offset` = offset − 0xE000, `rsp_ns_view` = 0 and no error.
- R6: Any other offset (for example the unimplemented trace area at 0x1000) selects the default responder, with `rsp_offset` equal to the window offset and `rsp_ns_view` = 0. A privileged read or write there completes with `rsp_error` = 0 and `rsp_rdata` = 0.
- R7: An unprivileged access that reaches the default responder returns `rsp_error` = 1. Unprivileged accesses to the timer or the system registers return no error from this block.
- R8: `req_size` gives the access size in bytes. A size of 0 or above 8 routes to the default responder with `rsp_error` = 1, whatever the address and privilege. Sizes 1 to 8 are legal.
- R9: With `SECURE_EXT` = 1, offsets 0x2E010 to 0x2E0EF select the timer and offsets 0x2E000 to 0x2EFFF outside that range select the system registers. Both have `rsp_ns_view` = 1 and the offset taken from the alias base.
- R10: With `SECURE_EXT` = 0, the alias offsets 0x2E000 to 0x2EFFF behave as default-responder space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Absolute byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Access size in bytes |
| req_priv | input | 1 | 1 = privileged access |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| sel_sysreg | output | 1 | System-register target chosen |
| sel_timer | output | 1 | Timer target chosen |
| sel_default | output | 1 | Default responder chosen |
| rsp_offset | output | 20 | Offset from the chosen target's base |
| rsp_ns_view | output | 1 | Access hit a non-secure alias |
| rsp_error | output | 1 | Bus error response |
| rsp_rdata | output | 64 | Read data for default-responder hits (zero) |

## Verification
The bench drives directed addresses at every range edge: 0xDFFF/0xE000, 0xE00F/0xE010, 0xE0EF/0xE0F0, 0xEFFF/0xF000 and their alias twins. These show whether the priority nesting and the bounds are off by one. The same addresses are also sent with random upper bits, which would expose any decode that looks beyond the window. Random accesses are concentrated around the two targets and their aliases and mix privilege, direction and size, including illegal sizes. This separates the size fault, the privilege fault and the legal completions. Every access is applied at once to a secure-extension instance and a plain instance, so the alias space is compared in both configurations.

// File: rtl/ppb_dec_pkg.sv
// Shared types and helpers for the private peripheral window decoder.
// Assumes access sizes are carried as a byte count in SIZE_W bits.
package ppb_dec_pkg;

    localparam int SIZE_W  = 4;
    localparam int MAX_ACC = 8;

    typedef enum logic [1:0] {
        TGT_NONE    = 2'd0,
        TGT_DEFAULT = 2'd1,
        TGT_SYSREG  = 2'd2,
        TGT_TIMER   = 2'd3
    } ppb_tgt_e;

    // Legal sizes run from one byte up to MAX_ACC bytes.
    function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
        return (sz != '0) && (int'(sz) <= MAX_ACC);
    endfunction

endpackage

// File: rtl/ppb_range_match.sv
// Compares a window offset against one [BASE, BASE+LEN) range.
// Produces the hit flag and the offset relative to BASE.
// Assumes BASE+LEN fits in AW+1 bits; the enable input masks the range off.
module ppb_range_match #(
    parameter int              AW   = 20,
    parameter logic [AW-1:0]   BASE = '0,
    parameter int              LEN  = 1
) (
    input  logic          enable,
    input  logic [AW-1:0] wofs,
    output logic          hit,
    output logic [AW-1:0] local_ofs
);
    localparam logic [AW:0] LO_EXT = {1'b0, BASE};
    localparam logic [AW:0] LIMIT  = LO_EXT + (AW+1)'(LEN);

    // Bounds test and rebasing of the offset.
    always_comb begin
        hit       = enable && ({1'b0, wofs} >= LO_EXT) && ({1'b0, wofs} < LIMIT);
        local_ofs = wofs - BASE;
    end
endmodule

// File: rtl/ppb_priority_pick.sv
// Picks the highest-ranked hit among N range matchers.
// Ranges flagged in IS_TIMER rank above the others.
// Assumes ranges of equal rank never overlap, so ties cannot occur.
module ppb_priority_pick
    import ppb_dec_pkg::*;
#(
    parameter int            N        = 4,
    parameter int            AW       = 20,
    parameter logic [N-1:0]  IS_TIMER = '0,
    parameter logic [N-1:0]  IS_ALIAS = '0
) (
    input  logic [N-1:0]         hit,
    input  logic [N-1:0][AW-1:0] local_ofs,
    output logic                 found,
    output ppb_tgt_e             tgt,
    output logic                 ns,
    output logic [AW-1:0]        ofs
);
    // Scan all ranges and keep the hit with the highest rank.
    always_comb begin
        logic [1:0] best;
        logic [1:0] lvl;
        best  = 2'd0;
        found = 1'b0;
        tgt   = TGT_NONE;
        ns    = 1'b0;
        ofs   = '0;
        for (int i = 0; i < N; i++) begin
            lvl = IS_TIMER[i] ? 2'd2 : 2'd1;
            if (hit[i] && (lvl > best)) begin
                best  = lvl;
                found = 1'b1;
                tgt   = IS_TIMER[i] ? TGT_TIMER : TGT_SYSREG;
                ns    = IS_ALIAS[i];
                ofs   = local_ofs[i];
            end
        end
    end
endmodule

// File: rtl/ppb_default_resp.sv
// Built-in responder for unclaimed window space.
// Reads as zero and ignores writes.
// Faults on an illegal size or an unprivileged access.
// Assumes the caller applies the fault only when this responder is chosen.
module ppb_default_resp
    import ppb_dec_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [SIZE_W-1:0] size,
    input  logic              priv,
    output logic              size_bad,
    output logic              fault,
    output logic [DW-1:0]     rdata
);
    // Size legality and privilege fault.
    always_comb begin
        size_bad = !size_legal(size);
        fault    = size_bad || !priv;
        rdata    = '0;
    end
endmodule

// File: rtl/ppb_window_decoder.sv
// Registered decoder for a 1 MB private peripheral window.
// Routes each access to the timer, the system registers or the default responder, by fixed rank.
// SECURE_EXT adds non-secure alias copies at +ALIAS_DELTA.
// Assumes the upstream fabric presents only in-window addresses, so bits above WIN_AW are ignored.
module ppb_window_decoder
    import ppb_dec_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                WIN_AW      = 20,
    parameter int                DATA_W      = 64,
    parameter bit                SECURE_EXT  = 1'b1,
    parameter logic [WIN_AW-1:0] SYSREG_BASE = 20'h0E000,
    parameter int                SYSREG_LEN  = 32'h1000,
    parameter logic [WIN_AW-1:0] TIMER_BASE  = 20'h0E010,
    parameter int                TIMER_LEN   = 32'hE0,
    parameter logic [WIN_AW-1:0] ALIAS_DELTA = 20'h20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic              sel_sysreg,
    output logic              sel_timer,
    output logic              sel_default,
    output logic [WIN_AW-1:0] rsp_offset,
    output logic              rsp_ns_view,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int           NREG     = 4;
    localparam logic [NREG-1:0] IS_TIMER = 4'b1010;
    localparam logic [NREG-1:0] IS_ALIAS = 4'b1100;

    logic [WIN_AW-1:0]            win_ofs;
    logic                         unused_bits;
    logic [NREG-1:0]              hit;
    logic [NREG-1:0][WIN_AW-1:0]  local_ofs;
    logic                         found;
    ppb_tgt_e                     pick_tgt;
    logic                         pick_ns;
    logic [WIN_AW-1:0]            pick_ofs;
    logic                         size_bad;
    logic                         dflt_fault;
    ppb_tgt_e                     nxt_tgt;
    logic                         nxt_ns;
    logic                         nxt_err;
    logic [WIN_AW-1:0]            nxt_ofs;

    assign win_ofs     = req_addr[WIN_AW-1:0];
    assign unused_bits = ^{req_addr[ADDR_W-1:WIN_AW], req_write};

    // One range matcher per target view; the aliases exist only with SECURE_EXT.
    for (genvar g = 0; g < NREG; g++) begin : g_rng
        localparam logic [WIN_AW-1:0] SHIFT_G = (g >= 2) ? ALIAS_DELTA : {WIN_AW{1'b0}};
        localparam logic [WIN_AW-1:0] BASE_G  = (((g % 2) == 1) ? TIMER_BASE : SYSREG_BASE) + SHIFT_G;
        localparam int                LEN_G   = ((g % 2) == 1) ? TIMER_LEN : SYSREG_LEN;
        localparam bit                EN_G    = (g < 2) || SECURE_EXT;

        ppb_range_match #(
            .AW   (WIN_AW),
            .BASE (BASE_G),
            .LEN  (LEN_G)
        ) u_match (
            .enable    (EN_G),
            .wofs      (win_ofs),
            .hit       (hit[g]),
            .local_ofs (local_ofs[g])
        );
    end

    ppb_priority_pick #(
        .N        (NREG),
        .AW       (WIN_AW),
        .IS_TIMER (IS_TIMER),
        .IS_ALIAS (IS_ALIAS)
    ) u_pick (
        .hit       (hit),
        .local_ofs (local_ofs),
        .found     (found),
        .tgt       (pick_tgt),
        .ns        (pick_ns),
        .ofs       (pick_ofs)
    );

    ppb_default_resp #(
        .DW (DATA_W)
    ) u_dflt (
        .size     (req_size),
        .priv     (req_priv),
        .size_bad (size_bad),
        .fault    (dflt_fault),
        .rdata    (rsp_rdata)
    );

    // Final routing: an illegal size overrides any target hit.
    always_comb begin
        if (size_bad) begin
            nxt_tgt = TGT_DEFAULT;
            nxt_ns  = 1'b0;
            nxt_err = 1'b1;
            nxt_ofs = win_ofs;
        end else if (found) begin
            nxt_tgt = pick_tgt;
            nxt_ns  = pick_ns;
            nxt_err = 1'b0;
            nxt_ofs = pick_ofs;
        end else begin
            nxt_tgt = TGT_DEFAULT;
            nxt_ns  = 1'b0;
            nxt_err = dflt_fault;
            nxt_ofs = win_ofs;
        end
    end

    // Response register: one cycle from request to selects and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            sel_sysreg  <= 1'b0;
            sel_timer   <= 1'b0;
            sel_default <= 1'b0;
            rsp_offset  <= '0;
            rsp_ns_view <= 1'b0;
            rsp_error   <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            sel_sysreg  <= req_valid && (nxt_tgt == TGT_SYSREG);
            sel_timer   <= req_valid && (nxt_tgt == TGT_TIMER);
            sel_default <= req_valid && (nxt_tgt == TGT_DEFAULT);
            rsp_ns_view <= req_valid && nxt_ns;
            rsp_error   <= req_valid && nxt_err;
            if (req_valid) begin
                rsp_offset <= nxt_ofs;
            end
        end
    end
endmodule

// File: rtl/ppb_window_decoder_chk.sv
// Property checker for ppb_window_decoder, attached with bind.
// Observes only the decoder's ports.
module ppb_window_decoder_chk
    import ppb_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_AW = 20,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic [SIZE_W-1:0] req_size,
    input logic              req_priv,
    input logic              rsp_valid,
    input logic              sel_sysreg,
    input logic              sel_timer,
    input logic              sel_default,
    input logic [WIN_AW-1:0] rsp_offset,
    input logic              rsp_ns_view,
    input logic              rsp_error,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic unused_chk;
    assign unused_chk = ^{req_addr, req_write, rsp_offset, rsp_rdata};

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !sel_sysreg && !sel_timer && !sel_default && !rsp_error && !rsp_ns_view);

    a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({sel_sysreg, sel_timer, sel_default}) == 1);

    a_r7_unpriv_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && sel_default && !$past(req_priv)) |-> rsp_error);

    a_r7_target_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !sel_default) |-> !rsp_error);

    a_r8_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !size_legal($past(req_size))) |-> (sel_default && rsp_error));

    a_r6_priv_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && sel_default && $past(req_priv) && size_legal($past(req_size))) |-> !rsp_error);

    a_r9_ns_only_alias: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ns_view |-> (rsp_valid && !sel_default));
endmodule

bind ppb_window_decoder ppb_window_decoder_chk #(
    .ADDR_W (ADDR_W),
    .WIN_AW (WIN_AW),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_priv    (req_priv),
    .rsp_valid   (rsp_valid),
    .sel_sysreg  (sel_sysreg),
    .sel_timer   (sel_timer),
    .sel_default (sel_default),
    .rsp_offset  (rsp_offset),
    .rsp_ns_view (rsp_ns_view),
    .rsp_error   (rsp_error),
    .rsp_rdata   (rsp_rdata)
);

// File: tb/ppb_window_decoder_bench.sv
// Bench: two decoders (with and without the security extension) share the same stimulus.
// Each response is compared with a bench model written from the requirements.
module ppb_window_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_size = 4'd4;
    logic        req_priv = 1'b1;

    logic        s_v, s_sy, s_tm, s_df, s_ns, s_er;
    logic [19:0] s_of;
    logic [63:0] s_rd;
    logic        n_v, n_sy, n_tm, n_df, n_ns, n_er;
    logic [19:0] n_of;
    logic [63:0] n_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ppb_window_decoder #(.SECURE_EXT(1'b1)) u_ppb_window_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
        .rsp_valid(s_v), .sel_sysreg(s_sy), .sel_timer(s_tm), .sel_default(s_df),
        .rsp_offset(s_of), .rsp_ns_view(s_ns), .rsp_error(s_er), .rsp_rdata(s_rd));

    ppb_window_decoder #(.SECURE_EXT(1'b0)) u_ppb_window_decoder_plain (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_priv(req_priv),
        .rsp_valid(n_v), .sel_sysreg(n_sy), .sel_timer(n_tm), .sel_default(n_df),
        .rsp_offset(n_of), .rsp_ns_view(n_ns), .rsp_error(n_er), .rsp_rdata(n_rd));

    // Expected {valid, timer, sysreg, default, ns, err, offset}.
    function automatic logic [25:0] model(input logic [31:0] a, input logic [3:0] sz,
                                          input bit pr, input bit sec);
        logic [19:0] o;
        o = a[19:0];
        if (sz == 0 || sz > 8)                              return {6'b100101, o};        // R8
        if (o >= 20'hE010 && o < 20'hE0F0)                  return {6'b110000, o - 20'hE010}; // R4
        if (sec && o >= 20'h2E010 && o < 20'h2E0F0)         return {6'b110010, o - 20'h2E010}; // R9
        if (o >= 20'hE000 && o < 20'hF000)                  return {6'b101000, o - 20'hE000}; // R5
        if (sec && o >= 20'h2E000 && o < 20'h2F000)         return {6'b101010, o - 20'h2E000}; // R9
        return {5'b10010, !pr, o};                           // R6, R7, R10
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [3:0] sz,
                                     input bit pr, input bit sec);
        logic [19:0] o;
        o = a[19:0];
        if (sz == 0 || sz > 8) return "R8";
        if (o >= 20'hE000 && o < 20'hF000) return (o >= 20'hE010 && o < 20'hE0F0) ? "R4" : "R5";
        if (o >= 20'h2E000 && o < 20'h2F000) return sec ? "R9" : "R10";
        return pr ? "R6" : "R7";
    endfunction

    task automatic compare(input string tag, input string who, input logic [25:0] act,
                           input logic [25:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
        end
    endtask

    // Apply one access (caller stands at a negedge), then check one cycle later.
    task automatic access(input logic [31:0] a, input logic [3:0] sz, input bit pr,
                          input bit wr, input string extra);
        logic [25:0] es, en;
        req_valid = 1'b1; req_addr = a; req_size = sz; req_priv = pr; req_write = wr;
        es = model(a, sz, pr, 1'b1);
        en = model(a, sz, pr, 1'b0);
        @(negedge clk);
        compare({tag_of(a, sz, pr, 1'b1), extra}, "sec",
                {s_v, s_tm, s_sy, s_df, s_ns, s_er, s_of}, es);
        compare({tag_of(a, sz, pr, 1'b0), extra}, "plain",
                {n_v, n_tm, n_sy, n_df, n_ns, n_er, n_of}, en);
        if (s_df) compare("R6 rdata", "sec", {s_rd[25:0] | 26'(|s_rd[63:26])}, 26'd0);
    endtask

    task automatic idle_check(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        compare(tag, "sec", {s_v, s_tm, s_sy, s_df, s_ns, s_er}, 26'd0);
        compare(tag, "plain", {n_v, n_tm, n_sy, n_df, n_ns, n_er}, 26'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] sizes [4];
        sizes = '{4'd1, 4'd2, 4'd4, 4'd8};
        void'($urandom(32'h5eed_0077));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1)
        compare("R1 reset", "sec", {s_v, s_tm, s_sy, s_df, s_ns, s_er}, 26'd0);
        compare("R1 reset", "plain", {n_v, n_tm, n_sy, n_df, n_ns, n_er}, 26'd0);

        // Directed range edges
        access(32'hE000_DFFF, 4'd4, 1'b1, 1'b0, " edge");
        access(32'hE000_E000, 4'd4, 1'b1, 1'b0, " edge");
        access(32'hE000_E00F, 4'd1, 1'b0, 1'b1, " edge");
        access(32'hE000_E010, 4'd4, 1'b0, 1'b0, " edge");
        access(32'hE000_E0EF, 4'd1, 1'b1, 1'b1, " edge");
        access(32'hE000_E0F0, 4'd4, 1'b1, 1'b0, " edge");
        access(32'hE000_EFFF, 4'd1, 1'b1, 1'b0, " edge");
        access(32'hE000_F000, 4'd4, 1'b1, 1'b0, " edge");
        access(32'hE000_1000, 4'd4, 1'b1, 1'b0, " trace area read");
        access(32'hE000_1004, 4'd4, 1'b1, 1'b1, " trace area write");
        access(32'hE000_1000, 4'd4, 1'b0, 1'b0, " trace area unpriv");
        access(32'hE002_E000, 4'd4, 1'b1, 1'b0, " alias edge");
        access(32'hE002_E010, 4'd4, 1'b1, 1'b0, " alias edge");
        access(32'hE002_E0EF, 4'd2, 1'b0, 1'b0, " alias edge");
        access(32'hE002_E0F0, 4'd4, 1'b1, 1'b0, " alias edge");
        access(32'hE002_EFFF, 4'd1, 1'b1, 1'b0, " alias edge");
        access(32'hE002_F000, 4'd4, 1'b0, 1'b0, " alias edge");
        access(32'hE002_DFFF, 4'd4, 1'b1, 1'b0, " alias edge");
        access(32'hE000_E020, 4'd0, 1'b1, 1'b0, " size 0");
        access(32'hE000_E800, 4'd9, 1'b1, 1'b0, " size 9");
        access(32'hE000_E800, 4'd8, 1'b0, 1'b0, " size 8 legal");
        access(32'hE000_0200, 4'd15, 1'b0, 1'b0, " size 15");
        // R3: upper bits vary, decode must not change
        access(32'h0000_E010, 4'd4, 1'b1, 1'b0, " R3 upper bits");
        access(32'hFFF0_E010, 4'd4, 1'b1, 1'b0, " R3 upper bits");
        access(32'h1230_E800, 4'd4, 1'b1, 1'b0, " R3 upper bits");
        idle_check("R1 idle");

        // Constrained random, back to back
        for (int i = 0; i < 4000; i++) begin
            logic [19:0] o;
            logic [3:0]  sz;
            case ($urandom % 7)
                0: o = 20'hE000 + 20'($urandom % 32'h1000);
                1: o = 20'hE000 + 20'($urandom % 32'h20);
                2: o = 20'hE0E0 + 20'($urandom % 32'h20);
                3: o = 20'h2E000 + 20'($urandom % 32'h100);
                4: o = 20'h2E000 + 20'($urandom % 32'h1000);
                5: o = 20'hEFF0 + 20'($urandom % 32'h20);
                default: o = 20'($urandom);
            endcase
            sz = (($urandom % 4) == 0) ? 4'($urandom) : sizes[$urandom % 4];
            access({12'($urandom), o}, sz, 1'($urandom), 1'($urandom), " random");
            if (($urandom % 50) == 0) idle_check("R1 idle random");
        end

        idle_check("R1 idle end");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule